// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes written over a small register bus into asynchronous serial frames on one output line. A frame-format register at bus offset 3 sets the number of data bits (5 to 8), the parity mode (none, odd, even, or a parity bit held at a fixed level), and the stop length (one, one and a half, or two bit times). The same register also holds a break control that forces the line low, and a bank-select bit that decides what bus offsets 0 and 1 reach.

With the bank-select bit clear, offset 0 is the transmit holding register. Offset 1 is an interrupt-enable slot that this block does not implement. With the bank-select bit set, offsets 0 and 1 load the low and high bytes of the baud divisor. A baud tick fires once every divisor clock cycles, and every bit lasts 16 ticks. The holding register is one byte deep. A byte written while a frame is on the line waits there and is sent when that frame ends.

Top module: `async_tx_top`

## Requirements
- R1: After reset, `txOut` is 1 and `busy` is 0. Whenever `busy` is 0 and break is off, `txOut` is 1.
- R2: Offset 3 holds the format register, laid out as follows. Bit 7 is bank select, bit 6 is break, bit 5 is fixed-level parity, bit 4 is even select, bit 3 is parity enable, bit 2 is long stop, and bits 1:0 are the word length. Word-length codes 0, 1, 2 and 3 send 5, 6, 7 and 8 data bits. A frame is one start bit at 0, then the data bits least significant first, then the optional parity bit, then the stop bits at 1.
- R3: With long stop at 0, the stop time is 16 ticks. With long stop at 1, it is 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words.
- R4: With parity enable at 0, no parity bit is sent, whatever bits 5 and 4 hold. With parity enable at 1 and bit 5 at 0, the parity bit is odd parity when bit 4 is 0 and even parity when bit 4 is 1.
- R5: With parity enable at 1 and bit 5 at 1, the parity bit is 1 when bit 4 is 0 and 0 when bit 4 is 1.
- R6: While the break bit is 1, `txOut` is 0. This holds when idle and during a frame. Clearing the break bit gives the line back to the frame logic.
- R7: With bank select at 1, offsets 0 and 1 write the low and high divisor bytes and start no frame. With bank select at 0, a write to offset 0 starts a frame, and a write to offset 1 changes neither the line nor the divisor.
- R8: The baud tick period is the divisor in clock cycles, with a divisor of 0 acting as 1. Every start, data and parity bit lasts 16 ticks. A frame lasts (1 + data bits + parity bits) × 16 × divisor + stop ticks × divisor cycles, counted from the falling edge of the start bit.
- R9: A byte written while a frame is in progress is held and sent after that frame. `busy` stays 1 throughout, and the next start bit follows the last stop cycle after exactly one idle cycle.
- R10: A byte written in the same cycle that the previous held byte moves to the shifter is kept, and it is sent as the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register offset |
| wrData | input | 8 | Write data byte |
| txOut | output | 1 | Serial line, idles at 1 |
| busy | output | 1 | Frame in progress or byte held |

## Verification
Two functions can fall in the same cycle. In one cycle the held byte moves into the shift register while a bus write refills the holding register. The bench provokes this by writing two bytes on consecutive clocks: the second write lands on the edge where the first byte is loaded into the shifter. The bench judges the result by decoding both frames from the line, checking their order and contents, and checking that there is exactly one idle cycle between them and that `busy` never drops.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_DATA_DIVLO = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_AUX_DIVHI  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LINE_CFG   = 3'd3;

  localparam int unsigned CFG_BANK_BIT   = 7;
  localparam int unsigned CFG_BREAK_BIT  = 6;
  localparam int unsigned CFG_STICK_BIT  = 5;
  localparam int unsigned CFG_EVEN_BIT   = 4;
  localparam int unsigned CFG_PAREN_BIT  = 3;
  localparam int unsigned CFG_LSTOP_BIT  = 2;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_PARITY, PH_STOP
  } phase_t;

  typedef struct packed {
    logic   loadFrame;
    logic   shiftData;
    phase_t phase;
  } ctrl_strobe_t;

  typedef struct packed {
    logic [1:0] wordLen;
    logic       parEn;
    logic       longStop;
  } frame_fmt_t;
endpackage

// File: rtl/async_tx_dp.sv
module async_tx_dp
  import async_tx_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [BUS_W-1:0]     wrData,
  input  ctrl_strobe_t         strobe,
  output logic                 holdFull,
  output logic                 baudTick,
  output frame_fmt_t           fmt,
  output logic                 lineBrk,
  output logic [DIV_W-1:0]     divisorEff,
  output logic                 txOut
);
  localparam int unsigned HI_W = DIV_W - BUS_W;

  logic [BUS_W-1:0] lineCfg;
  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] baudCnt;
  logic [BUS_W-1:0] holdReg;
  logic [BUS_W-1:0] shiftReg;
  logic             parityBit;
  logic             lineBit;

  logic bankSel, wrHold, wrDivLo, wrDivHi, wrCfg, baudRun;
  logic [BUS_W-1:0] wordMask;
  logic             dataOdd, parityNext;

  assign bankSel = lineCfg[CFG_BANK_BIT];
  assign wrHold  = wrEn && (wrAddr == ADDR_DATA_DIVLO) && !bankSel;
  assign wrDivLo = wrEn && (wrAddr == ADDR_DATA_DIVLO) && bankSel;
  assign wrDivHi = wrEn && (wrAddr == ADDR_AUX_DIVHI) && bankSel;
  assign wrCfg   = wrEn && (wrAddr == ADDR_LINE_CFG);
  assign lineBrk = lineCfg[CFG_BREAK_BIT];

  // Register bank
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCfg <= '0;
      divisor <= '0;
    end else begin
      if (wrCfg)   lineCfg <= wrData;
      if (wrDivLo) divisor[BUS_W-1:0] <= wrData;
      if (wrDivHi) divisor[DIV_W-1:BUS_W] <= wrData[HI_W-1:0];
    end
  end

  // Baud tick: counter held at zero while idle so every frame starts aligned
  assign divisorEff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign baudRun    = (strobe.phase != PH_IDLE);
  assign baudTick   = baudRun && (baudCnt == divisorEff - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     baudCnt <= '0;
    else if (!baudRun || baudTick) baudCnt <= '0;
    else                           baudCnt <= baudCnt + DIV_W'(1);
  end

  // Parity computed on the masked byte when it leaves the holding register
  assign wordMask = 8'hFF >> (2'd3 - lineCfg[1:0]);
  assign dataOdd  = ^(holdReg & wordMask);

  always_comb begin
    if (lineCfg[CFG_STICK_BIT]) parityNext = ~lineCfg[CFG_EVEN_BIT];
    else if (lineCfg[CFG_EVEN_BIT]) parityNext = dataOdd;
    else parityNext = ~dataOdd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull  <= 1'b0;
      holdReg   <= '0;
      shiftReg  <= '0;
      parityBit <= 1'b0;
      fmt       <= '0;
    end else begin
      if (wrHold)                holdFull <= 1'b1;
      else if (strobe.loadFrame) holdFull <= 1'b0;
      if (wrHold) holdReg <= wrData;
      if (strobe.loadFrame) begin
        shiftReg      <= holdReg;
        parityBit     <= parityNext;
        fmt.wordLen   <= lineCfg[1:0];
        fmt.parEn     <= lineCfg[CFG_PAREN_BIT];
        fmt.longStop  <= lineCfg[CFG_LSTOP_BIT];
      end else if (strobe.shiftData) begin
        shiftReg <= shiftReg >> 1;
      end
    end
  end

  always_comb begin
    unique case (strobe.phase)
      PH_START:  lineBit = 1'b0;
      PH_DATA:   lineBit = shiftReg[0];
      PH_PARITY: lineBit = parityBit;
      default:   lineBit = 1'b1;
    endcase
  end

  assign txOut = lineBrk ? 1'b0 : lineBit;
endmodule

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         holdFull,
  input  logic         baudTick,
  input  frame_fmt_t   fmt,
  output ctrl_strobe_t strobe,
  output logic         busy
);
  localparam int unsigned STOP_MAX = 2 * OVS;
  localparam int unsigned TCW      = $clog2(STOP_MAX + 1);
  localparam logic [TCW-1:0] BIT_LAST   = TCW'(OVS - 1);
  localparam logic [TCW-1:0] STOP1_LAST = TCW'(OVS - 1);
  localparam logic [TCW-1:0] STOPH_LAST = TCW'(OVS + OVS / 2 - 1);
  localparam logic [TCW-1:0] STOP2_LAST = TCW'(STOP_MAX - 1);

  phase_t         phase, phaseNext;
  logic [TCW-1:0] tickCnt, stopLast;
  logic [2:0]     bitIdx;
  logic           bitEnd, stopEnd, phaseEnd, lastData;

  always_comb begin
    if (!fmt.longStop)           stopLast = STOP1_LAST;
    else if (fmt.wordLen == 2'd0) stopLast = STOPH_LAST;
    else                         stopLast = STOP2_LAST;
  end

  assign bitEnd   = baudTick && (tickCnt == BIT_LAST);
  assign stopEnd  = baudTick && (tickCnt == stopLast);
  assign phaseEnd = (phase == PH_STOP) ? stopEnd : bitEnd;
  assign lastData = (bitIdx == {1'b1, fmt.wordLen});

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:   if (holdFull) phaseNext = PH_START;
      PH_START:  if (bitEnd) phaseNext = PH_DATA;
      PH_DATA:   if (bitEnd && lastData) phaseNext = fmt.parEn ? PH_PARITY : PH_STOP;
      PH_PARITY: if (bitEnd) phaseNext = PH_STOP;
      PH_STOP:   if (stopEnd) phaseNext = PH_IDLE;
      default:   phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      phase <= phaseNext;
      if (phase == PH_IDLE || phaseEnd) tickCnt <= '0;
      else if (baudTick)                tickCnt <= tickCnt + TCW'(1);
      if (phase == PH_START)                bitIdx <= '0;
      else if (phase == PH_DATA && bitEnd) bitIdx <= bitIdx + 3'd1;
    end
  end

  assign strobe.loadFrame = (phase == PH_IDLE) && holdFull;
  assign strobe.shiftData = (phase == PH_DATA) && bitEnd;
  assign strobe.phase     = phase;
  assign busy             = (phase != PH_IDLE) || holdFull;
endmodule

// File: rtl/async_tx_top.sv
module async_tx_top
  import async_tx_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned OVS   = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [7:0]  wrData,
  output logic        txOut,
  output logic        busy
);
  ctrl_strobe_t     strobe;
  frame_fmt_t       fmt;
  logic             holdFull, baudTick, lineBrk;
  logic [DIV_W-1:0] divisorEff;

  async_tx_dp #(.DIV_W(DIV_W)) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .holdFull(holdFull), .baudTick(baudTick), .fmt(fmt),
    .lineBrk(lineBrk), .divisorEff(divisorEff), .txOut(txOut)
  );

  async_tx_ctrl #(.OVS(OVS)) ctrl_i (
    .clk(clk), .rstN(rstN), .holdFull(holdFull), .baudTick(baudTick),
    .fmt(fmt), .strobe(strobe), .busy(busy)
  );
endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk
  import async_tx_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             txOut,
  input logic             busy,
  input logic             holdFull,
  input logic             baudTick,
  input logic             lineBrk,
  input logic [DIV_W-1:0] divisorEff,
  input ctrl_strobe_t     strobe
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !lineBrk) |-> txOut); // R1

  AST_BREAK_FORCES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    lineBrk |-> !txOut); // R6

  AST_LOAD_THEN_START: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFrame |=> !txOut); // R2

  AST_HELD_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    holdFull |-> busy); // R9

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (baudTick && divisorEff >= DIV_W'(2) && !wrEn) |=> !baudTick); // R8

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadFrame, strobe.shiftData})); // R10
endmodule

bind async_tx_top async_tx_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .txOut(txOut), .busy(busy),
  .holdFull(holdFull), .baudTick(baudTick), .lineBrk(lineBrk),
  .divisorEff(divisorEff), .strobe(strobe)
);

// File: tb/async_tx_top_tb_top.sv
`timescale 1ns/1ps
module async_tx_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       txOut, busy;

  int checks = 0;
  int fails  = 0;
  logic [7:0] curCfg = 8'h00;
  int curDiv = 1;

  always #2 clk = ~clk;

  async_tx_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .txOut(txOut), .busy(busy)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setCfg(input logic [7:0] c);
    curCfg = c;
    writeReg(3'd3, c);
  endtask

  task automatic setDiv(input int d);
    writeReg(3'd3, curCfg | 8'h80);
    writeReg(3'd0, d[7:0]);
    writeReg(3'd1, d[15:8]);
    writeReg(3'd3, curCfg);
    curDiv = (d == 0) ? 1 : d;
  endtask

  function automatic logic [7:0] mkCfg(int wl, bit pe, bit ev, bit st, bit ls);
    return {2'b00, st, ev, pe, ls, wl[1:0]};
  endfunction

  function automatic int frameLen(int nd, int p, int stopT, int d);
    return 16 * d * (1 + nd + p) + stopT * d;
  endfunction

  // Decodes one frame. n=0 is the first negedge with the start bit on the line.
  task automatic recvFrame(input bit started, input int nd, input int p, input int stopT,
                           output logic [7:0] data, output logic parBit, output int endN,
                           output bit nextSeen, output int busyLow, output bit stopOk);
    int d = curDiv;
    int stopStart = 16 * d * (1 + nd + p);
    int n = 0;
    int w = 0;
    data = '0; parBit = 1'b0; endN = -1; nextSeen = 0; busyLow = 0; stopOk = 0;
    if (!started) begin
      while (txOut !== 1'b0 && w < 5000) begin @(negedge clk); w++; end
    end
    while (n < 30000) begin
      @(negedge clk); n++;
      for (int k = 0; k < nd + p; k++)
        if (n == 16 * d * (1 + k) + 8 * d) begin
          if (k < nd) data[k] = txOut; else parBit = txOut;
        end
      if (n == stopStart + 4 * d) stopOk = txOut;
      if (!busy) begin busyLow++; endN = n; break; end
      if (n > stopStart && txOut === 1'b0) begin endN = n - 1; nextSeen = 1; break; end
    end
  endtask

  task automatic test_reset();
    check("R1", "txOut after reset", txOut, 1);
    check("R1", "busy after reset", busy, 0);
  endtask

  task automatic test_wordlen();
    logic [7:0] dat; logic pb; int e, bl; bit nx, so;
    setDiv(2);
    for (int wl = 0; wl < 4; wl++) begin
      setCfg(mkCfg(wl, 0, 0, 0, 0));
      writeReg(3'd0, 8'hB6);
      recvFrame(0, 5 + wl, 0, 16, dat, pb, e, nx, bl, so);
      check("R2", "data bits lsb first", dat, 8'hB6 & (8'hFF >> (3 - wl)));
      check("R8", "frame length", e, frameLen(5 + wl, 0, 16, 2));
      check("R1", "line high after frame", txOut, 1);
    end
  endtask

  task automatic test_stop();
    logic [7:0] dat; logic pb; int e, bl; bit nx, so;
    setCfg(mkCfg(0, 0, 0, 0, 1));
    writeReg(3'd0, 8'h15);
    recvFrame(0, 5, 0, 24, dat, pb, e, nx, bl, so);
    check("R3", "1.5 stop length 5-bit", e, frameLen(5, 0, 24, curDiv));
    check("R3", "stop level", so, 1);
    setCfg(mkCfg(2, 0, 0, 0, 1));
    writeReg(3'd0, 8'h55);
    recvFrame(0, 7, 0, 32, dat, pb, e, nx, bl, so);
    check("R3", "2 stop length 7-bit", e, frameLen(7, 0, 32, curDiv));
    check("R2", "7-bit data", dat, 8'h55);
  endtask

  task automatic test_parity();
    logic [7:0] dat; logic pb; int e, bl; bit nx, so;
    logic [7:0] vals [2] = '{8'h5A, 8'h07};
    for (int i = 0; i < 2; i++) begin
      for (int ev = 0; ev < 2; ev++) begin
        setCfg(mkCfg(3, 1, ev[0], 0, 0));
        writeReg(3'd0, vals[i]);
        recvFrame(0, 8, 1, 16, dat, pb, e, nx, bl, so);
        check("R4", ev ? "even parity bit" : "odd parity bit", pb, ev ? ^vals[i] : ~^vals[i]);
        check("R4", "parity frame length", e, frameLen(8, 1, 16, curDiv));
      end
    end
    setCfg(mkCfg(3, 0, 1, 1, 0));
    writeReg(3'd0, 8'h81);
    recvFrame(0, 8, 0, 16, dat, pb, e, nx, bl, so);
    check("R4", "no parity bit when disabled", e, frameLen(8, 0, 16, curDiv));
    for (int ev = 0; ev < 2; ev++) begin
      setCfg(mkCfg(3, 1, ev[0], 1, 0));
      writeReg(3'd0, 8'h5A);
      recvFrame(0, 8, 1, 16, dat, pb, e, nx, bl, so);
      check("R5", "fixed-level parity", pb, ev ? 0 : 1);
    end
  endtask

  task automatic test_break();
    int lowCnt = 0;
    setCfg(mkCfg(3, 0, 0, 0, 0) | 8'h40);
    repeat (3) @(negedge clk);
    check("R6", "break while idle", txOut, 0);
    setCfg(mkCfg(3, 0, 0, 0, 0));
    check("R6", "line restored after break", txOut, 1);
    writeReg(3'd0, 8'hFF);
    repeat (40) @(negedge clk);
    setCfg(mkCfg(3, 0, 0, 0, 0) | 8'h40);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (txOut === 1'b0) lowCnt++;
    end
    check("R6", "break held low mid-frame", lowCnt, 60);
    setCfg(mkCfg(3, 0, 0, 0, 0));
    while (busy) @(negedge clk);
    check("R6", "line high after break cleared", txOut, 1);
  endtask

  task automatic test_bank();
    logic [7:0] dat; logic pb; int e, bl; bit nx, so;
    int busySeen = 0;
    setCfg(mkCfg(3, 0, 0, 0, 0) | 8'h80);
    writeReg(3'd0, 8'h03);
    writeReg(3'd1, 8'h00);
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (busy) busySeen++; end
    check("R7", "divisor writes start no frame", busySeen, 0);
    setCfg(mkCfg(3, 0, 0, 0, 0));
    curDiv = 3;
    writeReg(3'd1, 8'h01);
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (busy) busySeen++; end
    check("R7", "offset 1 with bank 0 idle", busySeen, 0);
    writeReg(3'd0, 8'hC3);
    recvFrame(0, 8, 0, 16, dat, pb, e, nx, bl, so);
    check("R7", "divisor from bank writes, unchanged by offset 1", e, frameLen(8, 0, 16, 3));
    check("R7", "data after bank switch", dat, 8'hC3);
  endtask

  task automatic test_div0();
    logic [7:0] dat; logic pb; int e, bl; bit nx, so;
    setDiv(0);
    writeReg(3'd0, 8'h3C);
    recvFrame(0, 8, 0, 16, dat, pb, e, nx, bl, so);
    check("R8", "divisor 0 acts as 1", e, 160);
    check("R8", "data at divisor 1", dat, 8'h3C);
  endtask

  task automatic test_queue();
    logic [7:0] dat; logic pb; int e, bl; bit nx, so;
    setDiv(2);
    writeReg(3'd0, 8'h11);
    while (txOut !== 1'b0) @(negedge clk);
    repeat (30) @(negedge clk);
    writeReg(3'd0, 8'hE2);
    // Start bit detected 31 negedges ago; account for them in timing below
    recvFrame(1, 8, 0, 16, dat, pb, e, nx, bl, so);
    check("R9", "next start seen", nx, 1);
    check("R9", "busy never low between frames", bl, 0);
    check("R9", "first frame gap", e + 31, frameLen(8, 0, 16, 2));
    recvFrame(1, 8, 0, 16, dat, pb, e, nx, bl, so);
    check("R9", "held byte sent", dat, 8'hE2);
  endtask

  task automatic test_samecycle();
    logic [7:0] dat; logic pb; int e, bl; bit nx, so;
    wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'h96;
    @(negedge clk);
    wrData = 8'h4B;
    @(negedge clk);
    wrEn = 1'b0;
    recvFrame(0, 8, 0, 16, dat, pb, e, nx, bl, so);
    check("R10", "first byte", dat, 8'h96);
    check("R10", "second frame follows", nx, 1);
    check("R10", "exact gap", e, frameLen(8, 0, 16, 2));
    recvFrame(1, 8, 0, 16, dat, pb, e, nx, bl, so);
    check("R10", "byte written at load edge kept", dat, 8'h4B);
    check("R10", "busy drops after last", nx, 0);
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_wordlen();
    test_stop();
    test_parity();
    test_break();
    test_bank();
    test_div0();
    test_queue();
    test_samecycle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule